// File: doc/BRIEF.md
# Flagged multi-digit add/subtract unit

This unit adds or subtracts two unsigned integers of any length that sit in a word-addressed data memory. Each integer is kept as a run of 17-bit digits. Every digit is stored in an 18-bit word. Bit 17 of that word is set only on the most significant digit, so the length of a number is learned while it is read and is never given to the unit.

A caller gives three 16-bit base addresses: two sources and one destination. The caller also selects add or subtract, then pulses `start`. The unit walks the digits from least to most significant. It fetches one digit of each source through two separate memory ports and combines them with the carry or borrow left by the previous digit. It then writes the result digit back through the first port in the following cycle. When the flagged digit of the first source has been processed, the unit updates its carry and zero flags, pulses `done` and returns to idle.

The memory is outside the block and answers with fixed latency, so the edge has no valid/ready handshake. The rules are these:
- A read enable in one cycle has its data on the read-data pins in the next cycle.
- That data stays put until the next read on the same port.
- A write enable is committed at the clock edge that ends the cycle.
- Back-pressure does not exist: the unit issues at most one access per port per cycle and never waits.

Top module: `lnum_addsub`

## Requirements
- R1: After reset `busy`, `done`, `carry_flag` and `zero_flag` are 0, and no memory enable is asserted.
- R2: A word holds its digit in bits [16:0] and its end flag in bit 17. Digit i of an operand lives at base+i. Result digit i is written to destination base+i, with bit 17 set only on the last digit.
- R3: With `op_sub`=0 the written digits equal (A+B) mod 2^(17n), where n is the digit count. `carry_flag` is the carry out of the top digit.
- R4: With `op_sub`=1 the written digits equal (A−B) mod 2^(17n). `carry_flag` is 1 exactly when A<B, which is the borrow out of the top digit.
- R5: The digit count n is the position of the first source-A word with bit 17 set. End flags in source B are ignored. Exactly n result words are written and the word at destination base+n is left untouched.
- R6: `zero_flag` is 1 exactly when all n result digits are zero.
- R7: Both source reads are issued in the same cycle, and the write follows in the next cycle. `busy` is high for exactly 2n cycles and `done` is a single-cycle pulse in the first idle cycle.
- R8: `start`, bases and `op_sub` are sampled only while idle. A `start` pulse during a run changes neither that run's result nor any other memory word.
- R9: A destination base equal to a source base (in-place update) gives the correct result.
- R10: `carry_flag` and `zero_flag` keep their values from the previous operation until the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| src_a_base | input | 16 | First operand base address (defines length) |
| src_b_base | input | 16 | Second operand base address |
| dst_base | input | 16 | Result base address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_flag | output | 1 | Carry (add) or borrow (subtract) out of the top digit |
| zero_flag | output | 1 | Result is all zero |
| pa_en | output | 1 | Port A access enable |
| pa_we | output | 1 | Port A write enable |
| pa_addr | output | 16 | Port A address |
| pa_wdata | output | 18 | Port A write word |
| pa_rdata | input | 18 | Port A read word, one cycle after a read |
| pb_en | output | 1 | Port B read enable |
| pb_addr | output | 16 | Port B address |
| pb_rdata | input | 18 | Port B read word, one cycle after a read |

## Verification
The bench targets these corner cases and what a faulty design would show for each:
- An all-ones operand plus one must ripple a carry through every digit. A dropped inter-digit carry leaves nonzero digits and a clear carry flag.
- Equal operands subtracted must raise the zero flag, and a smaller minuend must raise the borrow. An inverted borrow sense flips both outcomes.
- A source-B word flagged early must not cut the run short. A unit that ends on either flag writes too few words and leaves the final flag missing.
- A single-digit operand and a 61-digit operand test the length bounds.
- An in-place update tests read-before-write ordering.
- A start pulse issued mid-run with decoy addresses would, if sampled, show up as writes to an unexpected address, which the scoreboard rejects.

// File: rtl/lnum_pkg.sv
package lnum_pkg;
  localparam int LNUM_DIGIT_W = 17;
  localparam int LNUM_ADDR_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } lnum_state_e;
endpackage

// File: rtl/lnum_addr_gen.sv
module lnum_addr_gen #(
  parameter int AW = 16,
  parameter int NP = 3
) (
  input  logic [NP-1:0][AW-1:0] base,
  input  logic [AW-1:0]         offset,
  output logic [NP-1:0][AW-1:0] addr
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    assign addr[p] = base[p] + offset;
  end
endmodule

// File: rtl/lnum_digit_alu.sv
module lnum_digit_alu #(
  parameter int DW = 17
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int EW = DW + 1;
  logic [EW-1:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b} - EW'(cin);
    else     ext = {1'b0, a} + {1'b0, b} + EW'(cin);
  end

  assign res  = ext[DW-1:0];
  assign cout = ext[DW];
endmodule

// File: rtl/lnum_seq_ctrl.sv
module lnum_seq_ctrl
  import lnum_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_sub,
  input  logic          last_digit,
  input  logic          digit_cout,
  input  logic          digit_zero,
  output logic          accept,
  output logic          rd_en,
  output logic          wr_en,
  output logic          busy,
  output logic          sub_mode,
  output logic          carry_in,
  output logic [AW-1:0] offset,
  output logic          done,
  output logic          carry_flag,
  output logic          zero_flag
);
  lnum_state_e state_q;
  logic [AW-1:0] idx_q;
  logic run_c_q, run_z_q, sub_q, done_q, cflag_q, zflag_q;

  assign accept = start && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      run_c_q <= 1'b0;
      run_z_q <= 1'b0;
      sub_q   <= 1'b0;
      done_q  <= 1'b0;
      cflag_q <= 1'b0;
      zflag_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sub_q   <= op_sub;
            idx_q   <= '0;
            run_c_q <= 1'b0;
            run_z_q <= 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_STORE;
        ST_STORE: begin
          run_c_q <= digit_cout;
          run_z_q <= run_z_q & digit_zero;
          if (last_digit) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            cflag_q <= digit_cout;
            zflag_q <= run_z_q & digit_zero;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en      = (state_q == ST_FETCH);
  assign wr_en      = (state_q == ST_STORE);
  assign busy       = (state_q != ST_IDLE);
  assign sub_mode   = sub_q;
  assign carry_in   = run_c_q;
  assign offset     = idx_q;
  assign done       = done_q;
  assign carry_flag = cflag_q;
  assign zero_flag  = zflag_q;

  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> wr_en);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({carry_flag, zero_flag}) |-> done);
  // R8
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(sub_q));
  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !last_digit) |=> (offset == $past(offset) + 1'b1));
endmodule

// File: rtl/lnum_addsub.sv
module lnum_addsub
  import lnum_pkg::*;
#(
  parameter int DIGIT_W = LNUM_DIGIT_W,
  parameter int ADDR_W  = LNUM_ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 op_sub,
  input  logic [ADDR_W-1:0]    src_a_base,
  input  logic [ADDR_W-1:0]    src_b_base,
  input  logic [ADDR_W-1:0]    dst_base,
  output logic                 busy,
  output logic                 done,
  output logic                 carry_flag,
  output logic                 zero_flag,
  output logic                 pa_en,
  output logic                 pa_we,
  output logic [ADDR_W-1:0]    pa_addr,
  output logic [DIGIT_W:0]     pa_wdata,
  input  logic [DIGIT_W:0]     pa_rdata,
  output logic                 pb_en,
  output logic [ADDR_W-1:0]    pb_addr,
  input  logic [DIGIT_W:0]     pb_rdata
);
  localparam int NPORT  = 3;
  localparam int FLAG_B = DIGIT_W;

  logic accept, rd_en, wr_en, sub_mode, carry_in, digit_cout, digit_zero;
  logic [ADDR_W-1:0] offset;
  logic [NPORT-1:0][ADDR_W-1:0] base_q, addr;
  logic [DIGIT_W-1:0] digit_res;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (accept) base_q <= {dst_base, src_b_base, src_a_base};
  end

  lnum_seq_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .last_digit(pa_rdata[FLAG_B]), .digit_cout(digit_cout), .digit_zero(digit_zero),
    .accept(accept), .rd_en(rd_en), .wr_en(wr_en), .busy(busy),
    .sub_mode(sub_mode), .carry_in(carry_in), .offset(offset), .done(done),
    .carry_flag(carry_flag), .zero_flag(zero_flag)
  );

  lnum_addr_gen #(.AW(ADDR_W), .NP(NPORT)) u_agen (
    .base(base_q), .offset(offset), .addr(addr)
  );

  lnum_digit_alu #(.DW(DIGIT_W)) u_alu (
    .a(pa_rdata[DIGIT_W-1:0]), .b(pb_rdata[DIGIT_W-1:0]), .sub(sub_mode),
    .cin(carry_in), .res(digit_res), .cout(digit_cout)
  );

  assign digit_zero = (digit_res == '0);
  assign pa_en      = rd_en | wr_en;
  assign pa_we      = wr_en;
  assign pa_addr    = wr_en ? addr[2] : addr[0];
  assign pa_wdata   = {pa_rdata[FLAG_B], digit_res};
  assign pb_en      = rd_en;
  assign pb_addr    = addr[1];

  // R7
  port_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) pa_we |-> !pb_en);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(pa_en || pb_en));
endmodule

// File: tb/lnum_addsub_tb.sv
module lnum_addsub_tb;
  localparam int DW = 17;
  localparam int AW = 16;
  localparam int MAXD = 64;
  localparam int BW = DW * MAXD + 1;
  typedef logic [BW-1:0] big_t;
  typedef struct { int addr; logic [DW:0] word; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_sub = 1'b0;
  logic [AW-1:0] src_a_base = '0, src_b_base = '0, dst_base = '0;
  logic busy, done, carry_flag, zero_flag;
  logic pa_en, pa_we, pb_en;
  logic [AW-1:0] pa_addr, pb_addr;
  logic [DW:0] pa_wdata, pa_rdata, pb_rdata;

  logic [DW:0] mem [0:1023];
  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lnum_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .src_a_base(src_a_base), .src_b_base(src_b_base), .dst_base(dst_base),
    .busy(busy), .done(done), .carry_flag(carry_flag), .zero_flag(zero_flag),
    .pa_en(pa_en), .pa_we(pa_we), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
    .pa_rdata(pa_rdata), .pb_en(pb_en), .pb_addr(pb_addr), .pb_rdata(pb_rdata)
  );

  always @(posedge clk) begin
    if (pa_en) begin
      if (pa_we) mem[pa_addr[9:0]] <= pa_wdata;
      else       pa_rdata <= mem[pa_addr[9:0]];
    end
    if (pb_en) pb_rdata <= mem[pb_addr[9:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every write must match the head of the queue (R2 R5 R8)
  always @(negedge clk) begin
    if (rst_n && pa_en && pa_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected write addr", 64'(pa_addr), 64'hFFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(pa_addr == AW'(e.addr), "R2", "write address", 64'(pa_addr), 64'(e.addr));
        check(pa_wdata == e.word, "R3/R4", "write word", 64'(pa_wdata), 64'(e.word));
      end
    end
  end

  task automatic run_op(input string req, input int ab, input int bb, input int db,
                        input bit sub, input int n, input big_t av, input big_t bv,
                        input bit b_early_flag, input bit glitch);
    big_t mask, r;
    bit ec, ez, pc, pz, held;
    int cyc, guard;
    mask = (big_t'(1) << (DW * n)) - 1'b1;
    for (int i = 0; i < n; i++) begin
      mem[ab + i] = {i == n - 1, av[DW*i +: DW]};
      mem[bb + i] = {(i == n - 1) || (b_early_flag && i == 0), bv[DW*i +: DW]};
    end
    mem[db + n] = 18'h2AAAA;
    if (sub) begin
      r  = (av - bv) & mask;
      ec = (av & mask) < (bv & mask);
    end else begin
      r  = (av & mask) + (bv & mask);
      ec = r[DW*n];
      r  = r & mask;
    end
    ez = (r == '0);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.addr = db + i;
      e.word = {i == n - 1, r[DW*i +: DW]};
      exp_q.push_back(e);
    end
    pc = carry_flag; pz = zero_flag; held = 1'b1;
    @(negedge clk);
    src_a_base = AW'(ab); src_b_base = AW'(bb); dst_base = AW'(db);
    op_sub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      src_a_base = 16'd950; src_b_base = 16'd960; dst_base = 16'd970;
      op_sub = ~sub; start = 1'b1;
    end
    cyc = 0; guard = 0;
    while (!done && guard < 4000) begin
      if (busy) cyc++;
      if (carry_flag != pc || zero_flag != pz) held = 1'b0;
      @(negedge clk);
      start = 1'b0;
      guard++;
    end
    if (guard >= 4000) begin
      check(1'b0, "R7", "watchdog expired", 64'(guard), 64'(2 * n));
    end else begin
      check(cyc == 2 * n, "R7", {req, " busy cycles"}, 64'(cyc), 64'(2 * n));
      check(carry_flag == ec, req, "carry_flag", 64'(carry_flag), 64'(ec));
      check(zero_flag == ez, "R6", "zero_flag", 64'(zero_flag), 64'(ez));
      check(held, "R10", "flags held during run", 64'(held), 64'd1);
      check(exp_q.size() == 0, "R5", "missing writes", 64'(exp_q.size()), 64'd0);
      check(mem[db + n] == 18'h2AAAA, "R5", "word past end", 64'(mem[db + n]), 64'h2AAAA);
      @(negedge clk);
      check(!done, "R7", "done one cycle", 64'(done), 64'd0);
    end
    exp_q.delete();
  endtask

  function automatic big_t rnd(input int n);
    big_t v = '0;
    for (int i = 0; i < n; i++) v[DW*i +: DW] = DW'($urandom);
    return v;
  endfunction

  initial begin
    big_t a, b;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !carry_flag && !zero_flag, "R1", "flags after reset",
          64'({busy, done, carry_flag, zero_flag}), 64'd0);
    check(!pa_en && !pb_en, "R1", "memory idle", 64'({pa_en, pb_en}), 64'd0);

    // R3 random add, 8 digits
    run_op("R3", 0, 100, 200, 1'b0, 8, rnd(8), rnd(8), 1'b0, 1'b0);
    // R4 subtract with A > B
    a = rnd(8); b = rnd(8); a[DW*7 +: DW] = 17'h1FFFF; b[DW*7 +: DW] = 17'h00001;
    run_op("R4", 0, 100, 200, 1'b1, 8, a, b, 1'b0, 1'b0);
    // R4 subtract with A < B gives borrow
    run_op("R4", 0, 100, 200, 1'b1, 8, a, a + 1'b1, 1'b0, 1'b0);
    // R3 R6 full carry ripple: all ones plus one
    a = (big_t'(1) << (DW * 5)) - 1'b1;
    run_op("R3", 10, 110, 210, 1'b0, 5, a, big_t'(1), 1'b0, 1'b0);
    // R6 equal operands subtract to zero
    a = rnd(6);
    run_op("R6", 10, 110, 210, 1'b1, 6, a, a, 1'b0, 1'b0);
    // R5 single digit
    run_op("R5", 30, 130, 230, 1'b0, 1, rnd(1), rnd(1), 1'b0, 1'b0);
    // R5 early end flag in B is ignored
    run_op("R5", 40, 140, 240, 1'b0, 7, rnd(7), rnd(7), 1'b1, 1'b0);
    // R8 start pulsed mid-run with decoy bases
    run_op("R8", 50, 150, 250, 1'b0, 9, rnd(9), rnd(9), 1'b0, 1'b1);
    // R9 in place: destination is source A
    run_op("R9", 300, 400, 300, 1'b1, 10, rnd(10), rnd(10), 1'b0, 1'b0);
    // R7 long operand, 61 digits
    run_op("R7", 500, 600, 700, 1'b0, 61, rnd(61), rnd(61), 1'b0, 1'b0);
    // R4 long subtract
    run_op("R4", 500, 600, 700, 1'b1, 61, rnd(61), rnd(61), 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL R7 global watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule